// File: doc/BRIEF.md
# Floating-Point Out-of-Range Result Fixup

This block is the last stage of a floating-point result path. It receives a rounded result in unpacked form: sign, exponent with unbounded range, fraction, and upstream indications of tininess, loss of accuracy and rounding inexactness. It also receives the rounding mode, the precision select and the overflow and underflow trap enables. From these it decides what is actually delivered: the normally biased encoding, an exponent-wrapped encoding for a trapped overflow or underflow, or the default result for an untrapped one. Alongside the result it raises the overflow, underflow and inexact flags, a fraction-inexact bit and a class code.

Normalization, rounding and denormalization are done upstream. When an untrapped underflow occurs, the supplied fraction is taken to be the already denormalized value. The block is one register stage. Every output reflects the inputs present at the previous rising clock edge.

Top module: `fpfix_top`

## Requirements
- R1: When the exponent is within range and tiny_i is low, the result is the sign, the exponent plus bias (1023 for double, 127 for single) and the fraction. The class is normal, overflow and underflow are 0, and inx_o and fi_o equal inexact_i. All outputs appear one clock after the inputs.
- R2: Overflow is flagged when exp_i (signed, unbiased) exceeds 1023 for double or 127 for single, whatever the enable. It has priority over tiny_i. exp_i equal to the maximum is not an overflow.
- R3: With ovf_en_i high, an overflow delivers an exponent field of exp_i - 1536 + 1023 for double, or exp_i - 192 + 127 for single. The fraction passes through, the class is normal, and inx_o and fi_o equal inexact_i.
- R4: For a tiny result, underflow is flagged when unf_en_i is high, or when unf_en_i is low and lossy_i is high. Otherwise it is 0.
- R5: With unf_en_i high, a tiny result delivers an exponent field of exp_i + 1536 + 1023 for double, or exp_i + 192 + 127 for single. The fraction passes through and the class is normal.
- R6: With unf_en_i low, a tiny result delivers an exponent field of 0 and the supplied fraction. The class is zero when that fraction is zero, and denormal otherwise.
- R7: An overflow with ovf_en_i low forces inx_o and fi_o to 1.
- R8: An untrapped overflow gives signed infinity in round to nearest (rmode_i 00). In round toward zero (01) it gives the signed largest finite number: exponent all ones minus one, fraction all ones.
- R9: An untrapped overflow in round toward plus infinity (10) gives +infinity for a positive result and the largest finite number with negative sign for a negative one. Round toward minus infinity (11) gives -infinity for a negative result and the largest positive finite number for a positive one.
- R10: class_o is {sign, infinity, normal, denormal, zero} from bit 4 down to bit 0. Exactly one of bits 3..0 is set, and bit 4 equals the result sign.
- R11: With single_i high, the result occupies result_o[31:0] as sign, 8-bit exponent and 23-bit fraction taken from frac_i[51:29]. result_o[63:32] is zero. With single_i low, all 64 bits hold the double encoding.
- R12: While rst_n is low, result_o and all flags are 0 and class_o is 00001 (positive zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the rounded result |
| exp_i | input | 13 | Signed unbiased exponent of the rounded result, unbounded range |
| frac_i | input | 52 | Fraction without hidden bit, left aligned |
| tiny_i | input | 1 | Result is tiny |
| lossy_i | input | 1 | Loss of accuracy on denormalization |
| inexact_i | input | 1 | Rounded value differs from the exact value |
| rmode_i | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 plus inf, 11 minus inf |
| single_i | input | 1 | 1 selects single precision, 0 double |
| ovf_en_i | input | 1 | Overflow trap enable |
| unf_en_i | input | 1 | Underflow trap enable |
| result_o | output | 64 | Delivered result encoding |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inx_o | output | 1 | Inexact flag |
| fi_o | output | 1 | Fraction-inexact bit |
| class_o | output | 5 | Result class code |

## Verification
The hardest cases to reach are at the edges of each precision's exponent range, meeting the enable settings. Examples are exp_i exactly at the maximum against one above it, a tiny result that is exact and so raises no disabled underflow, and a tiny indication arriving with an overflowing exponent. Random vectors would rarely land on these, so directed vectors place them. Random vectors are then drawn per category: in-range, overflow and tiny exponent windows for each precision. They cover every rounding mode, sign and enable combination.

// File: rtl/fpfix_pkg.sv
package fpfix_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } fpfix_rmode_t;

    typedef struct packed {
        logic neg;
        logic inf;
        logic norm;
        logic den;
        logic zero;
    } fpfix_class_t;

    typedef struct packed {
        logic         ovf;
        logic         unf;
        logic         inx;
        logic         fi;
        fpfix_class_t cls;
    } fpfix_stat_t;

    typedef struct packed {
        logic [63:0] res;
        fpfix_stat_t st;
    } fpfix_out_t;

endpackage

// File: rtl/fpfix_ovf_default.sv
module fpfix_ovf_default
    import fpfix_pkg::*;
#(
    parameter int EW = 11,
    parameter int FW = 52
) (
    input  logic          sign_i,
    input  fpfix_rmode_t  rmode_i,
    output logic [EW-1:0] fld_o,
    output logic [FW-1:0] frac_o,
    output logic          is_inf_o
);
    localparam logic [EW-1:0] EXP_ONES = {EW{1'b1}};
    localparam logic [EW-1:0] EXP_MAXF = EXP_ONES - 1'b1;

    logic to_inf;

    always_comb begin
        unique case (rmode_i)
            RM_NEAR: to_inf = 1'b1;
            RM_ZERO: to_inf = 1'b0;
            RM_UP:   to_inf = ~sign_i;
            RM_DOWN: to_inf = sign_i;
            default: to_inf = 1'b1;
        endcase
        if (to_inf) begin
            fld_o  = EXP_ONES;
            frac_o = '0;
        end else begin
            fld_o  = EXP_MAXF;
            frac_o = '1;
        end
        is_inf_o = to_inf;
    end
endmodule

// File: rtl/fpfix_fmt_path.sv
module fpfix_fmt_path
    import fpfix_pkg::*;
#(
    parameter int EW = 11,
    parameter int FW = 52,
    parameter int XW = 13
) (
    input  logic                sign_i,
    input  logic signed [XW-1:0] exp_i,
    input  logic [FW-1:0]       frac_i,
    input  logic                tiny_i,
    input  logic                lossy_i,
    input  logic                inexact_i,
    input  fpfix_rmode_t        rmode_i,
    input  logic                ovf_en_i,
    input  logic                unf_en_i,
    output logic [EW+FW:0]      res_o,
    output fpfix_stat_t         st_o
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int WRAP = 3 << (EW - 2);
    localparam int EMAX = BIAS;

    int            e_ext;
    logic          over;
    logic [EW-1:0] fld_norm;
    logic [EW-1:0] fld_ovf_wrap;
    logic [EW-1:0] fld_unf_wrap;
    logic [EW-1:0] dflt_fld;
    logic [FW-1:0] dflt_frac;
    logic          dflt_inf;

    assign e_ext        = int'(exp_i);
    assign over         = e_ext > EMAX;
    assign fld_norm     = EW'(e_ext + BIAS);
    assign fld_ovf_wrap = EW'(e_ext - WRAP + BIAS);
    assign fld_unf_wrap = EW'(e_ext + WRAP + BIAS);

    fpfix_ovf_default #(.EW(EW), .FW(FW)) dflt_i (
        .sign_i   (sign_i),
        .rmode_i  (rmode_i),
        .fld_o    (dflt_fld),
        .frac_o   (dflt_frac),
        .is_inf_o (dflt_inf)
    );

    logic [EW-1:0] fld;
    logic [FW-1:0] frc;

    always_comb begin
        fld         = fld_norm;
        frc         = frac_i;
        st_o        = '0;
        st_o.inx    = inexact_i;
        st_o.fi     = inexact_i;
        st_o.cls.neg  = sign_i;
        st_o.cls.norm = 1'b1;
        if (over) begin
            st_o.ovf = 1'b1;
            if (ovf_en_i) begin
                fld = fld_ovf_wrap;
            end else begin
                fld           = dflt_fld;
                frc           = dflt_frac;
                st_o.inx      = 1'b1;
                st_o.fi       = 1'b1;
                st_o.cls.inf  = dflt_inf;
                st_o.cls.norm = ~dflt_inf;
            end
        end else if (tiny_i) begin
            st_o.unf = unf_en_i | lossy_i;
            if (unf_en_i) begin
                fld = fld_unf_wrap;
            end else begin
                fld           = '0;
                st_o.cls.norm = 1'b0;
                st_o.cls.zero = (frac_i == '0);
                st_o.cls.den  = (frac_i != '0);
            end
        end
        res_o = {sign_i, fld, frc};
    end
endmodule

// File: rtl/fpfix_top.sv
module fpfix_top
    import fpfix_pkg::*;
#(
    parameter int XW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sign_i,
    input  logic [XW-1:0] exp_i,
    input  logic [51:0]   frac_i,
    input  logic          tiny_i,
    input  logic          lossy_i,
    input  logic          inexact_i,
    input  logic [1:0]    rmode_i,
    input  logic          single_i,
    input  logic          ovf_en_i,
    input  logic          unf_en_i,
    output logic [63:0]   result_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          inx_o,
    output logic          fi_o,
    output logic [4:0]    class_o
);
    localparam int DEW = 11;
    localparam int DFW = 52;
    localparam int SEW = 8;
    localparam int SFW = 23;

    fpfix_rmode_t rm;
    assign rm = fpfix_rmode_t'(rmode_i);

    logic [DEW+DFW:0] d_res;
    logic [SEW+SFW:0] s_res;
    fpfix_stat_t      d_st;
    fpfix_stat_t      s_st;

    fpfix_fmt_path #(.EW(DEW), .FW(DFW), .XW(XW)) dbl_i (
        .sign_i (sign_i), .exp_i (exp_i), .frac_i (frac_i),
        .tiny_i (tiny_i), .lossy_i (lossy_i), .inexact_i (inexact_i),
        .rmode_i (rm), .ovf_en_i (ovf_en_i), .unf_en_i (unf_en_i),
        .res_o (d_res), .st_o (d_st)
    );

    logic [28:0] unused_low;
    assign unused_low = frac_i[28:0];

    fpfix_fmt_path #(.EW(SEW), .FW(SFW), .XW(XW)) sgl_i (
        .sign_i (sign_i), .exp_i (exp_i), .frac_i (frac_i[51:29]),
        .tiny_i (tiny_i), .lossy_i (lossy_i), .inexact_i (inexact_i),
        .rmode_i (rm), .ovf_en_i (ovf_en_i), .unf_en_i (unf_en_i),
        .res_o (s_res), .st_o (s_st)
    );

    fpfix_out_t out_d, out_q;

    always_comb begin
        if (single_i) begin
            out_d.res = {32'b0, s_res};
            out_d.st  = s_st;
        end else begin
            out_d.res = d_res;
            out_d.st  = d_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q          <= '0;
            out_q.st.cls.zero <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign ovf_o    = out_q.st.ovf;
    assign unf_o    = out_q.st.unf;
    assign inx_o    = out_q.st.inx;
    assign fi_o     = out_q.st.fi;
    assign class_o  = out_q.st.cls;

    // Registered stage checks
    assert_class_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(class_o[3:0]));

    assert_class_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        class_o[4] == ($past(single_i) ? result_o[31] : result_o[63]));

    assert_dis_ovf_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !$past(ovf_en_i)) |-> (inx_o && fi_o));

    assert_unf_needs_tiny_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> $past(tiny_i));

    assert_dis_unf_lossy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_o && !$past(unf_en_i)) |-> $past(lossy_i));

    assert_no_ovf_unf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    assert_single_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(single_i) |-> (result_o[63:32] == 32'b0));
endmodule

// File: tb/fpfix_top_tb_top.sv
module fpfix_top_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        sign_i, tiny_i, lossy_i, inexact_i, single_i, ovf_en_i, unf_en_i;
    logic [12:0] exp_i;
    logic [51:0] frac_i;
    logic [1:0]  rmode_i;
    logic [63:0] result_o;
    logic        ovf_o, unf_o, inx_o, fi_o;
    logic [4:0]  class_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    fpfix_top dut_i (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .frac_i(frac_i),
        .tiny_i(tiny_i), .lossy_i(lossy_i), .inexact_i(inexact_i), .rmode_i(rmode_i),
        .single_i(single_i), .ovf_en_i(ovf_en_i), .unf_en_i(unf_en_i),
        .result_o(result_o), .ovf_o(ovf_o), .unf_o(unf_o), .inx_o(inx_o),
        .fi_o(fi_o), .class_o(class_o)
    );

    function automatic void model(
        input logic s, input int e, input logic [51:0] f, input logic ti, lo, ix,
        input logic [1:0] rm, input logic sg, oe, ue,
        output logic [63:0] r, output logic ov, un, inx, fi, output logic [4:0] cl);
        int bias, wrap, fld, ones;
        logic [51:0] fr;
        logic inf, nrm, den, zer, toinf;
        bias = sg ? 127 : 1023;
        wrap = sg ? 192 : 1536;
        ones = sg ? 255 : 2047;
        fr   = sg ? {29'b0, f[51:29]} : f;
        ov = (e > bias); un = 1'b0; inx = ix; fi = ix;
        inf = 0; nrm = 1; den = 0; zer = 0;
        fld = e + bias;
        if (ov) begin
            if (oe) fld = e - wrap + bias;
            else begin
                inx = 1; fi = 1;
                toinf = (rm == 2'b00) || (rm == 2'b10 && !s) || (rm == 2'b11 && s);
                if (toinf) begin fld = ones; fr = '0; inf = 1; nrm = 0; end
                else begin fld = ones - 1; fr = '1; end
            end
        end else if (ti) begin
            un = ue | lo;
            if (ue) fld = e + wrap + bias;
            else begin
                fld = 0; nrm = 0;
                zer = (fr == '0); den = (fr != '0);
            end
        end
        if (sg) r = {32'b0, s, fld[7:0], fr[22:0]};
        else    r = {s, fld[10:0], fr};
        cl = {s, inf, nrm, den, zer};
    endfunction

    task automatic apply(input string tag, input logic s, input int e, input logic [51:0] f,
                         input logic ti, lo, ix, input logic [1:0] rm,
                         input logic sg, oe, ue);
        logic [63:0] er; logic eov, eun, einx, efi; logic [4:0] ecl;
        sign_i = s; exp_i = e[12:0]; frac_i = f; tiny_i = ti; lossy_i = lo;
        inexact_i = ix; rmode_i = rm; single_i = sg; ovf_en_i = oe; unf_en_i = ue;
        model(s, e, f, ti, lo, ix, rm, sg, oe, ue, er, eov, eun, einx, efi, ecl);
        @(posedge clk);
        @(negedge clk);
        total++;
        if (result_o !== er || ovf_o !== eov || unf_o !== eun || inx_o !== einx ||
            fi_o !== efi || class_o !== ecl) begin
            bad++;
            $display("FAIL %s: got res=%h o=%b u=%b x=%b fi=%b cl=%b exp res=%h o=%b u=%b x=%b fi=%b cl=%b",
                     tag, result_o, ovf_o, unf_o, inx_o, fi_o, class_o,
                     er, eov, eun, einx, efi, ecl);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [51:0] fa;
        void'($urandom(32'd20240611));
        rst_n = 0; sign_i = 0; exp_i = 0; frac_i = 0; tiny_i = 0; lossy_i = 0;
        inexact_i = 0; rmode_i = 0; single_i = 0; ovf_en_i = 0; unf_en_i = 0;
        repeat (3) @(negedge clk);
        total++;
        if (result_o !== 64'b0 || ovf_o || unf_o || inx_o || fi_o || class_o !== 5'b00001) begin
            bad++;
            $display("FAIL R12: got res=%h cl=%b exp res=0 cl=00001", result_o, class_o);
        end
        rst_n = 1;
        fa = 52'h5_A5A5_1234_5678;
        // directed corners
        apply("R1",  0, 10,    fa, 0, 0, 1, 2'b00, 0, 0, 0);
        apply("R1",  1, -1022, fa, 0, 0, 0, 2'b00, 0, 0, 0);
        apply("R2",  0, 1023,  fa, 0, 0, 0, 2'b00, 0, 0, 0);
        apply("R2",  0, 1024,  fa, 1, 1, 0, 2'b00, 0, 1, 1);
        apply("R2",  0, 127,   fa, 0, 0, 0, 2'b01, 1, 0, 0);
        apply("R3",  1, 1500,  fa, 0, 0, 1, 2'b00, 0, 1, 0);
        apply("R3",  0, 200,   fa, 0, 0, 0, 2'b00, 1, 1, 0);
        for (int m = 0; m < 4; m++) begin
            apply("R8 R9 R7", 0, 1100, fa, 0, 0, 0, m[1:0], 0, 0, 0);
            apply("R8 R9 R7", 1, 1100, fa, 0, 0, 0, m[1:0], 0, 0, 0);
            apply("R9 R11",   1, 128,  fa, 0, 0, 0, m[1:0], 1, 0, 0);
        end
        apply("R5",  0, -1100, fa, 1, 0, 1, 2'b00, 0, 0, 1);
        apply("R5",  1, -150,  fa, 1, 1, 0, 2'b00, 1, 0, 1);
        apply("R6 R4", 0, -1030, fa, 1, 1, 1, 2'b00, 0, 0, 0);
        apply("R4 R10", 1, -1030, 52'h0, 1, 0, 0, 2'b00, 0, 0, 0);
        apply("R6 R11", 0, -130, fa, 1, 0, 0, 2'b00, 1, 0, 0);
        apply("R11", 1, -3, fa, 0, 0, 1, 2'b00, 1, 0, 0);
        // constrained random per category
        for (int i = 0; i < 3000; i++) begin
            logic sg; int bias, e, cat; logic [51:0] f;
            sg   = $urandom_range(0, 1);
            bias = sg ? 127 : 1023;
            cat  = $urandom_range(0, 2);
            f    = {$urandom(), $urandom()};
            if ($urandom_range(0, 7) == 0) f = '0;
            if (cat == 0) e = $urandom_range(0, 2 * bias - 1) - (bias - 1);
            else if (cat == 1) e = bias + 1 + $urandom_range(0, 300);
            else e = -bias - $urandom_range(0, 300);
            apply(cat == 0 ? "R1" : (cat == 1 ? "R2 R3 R8" : "R4 R5 R6"),
                  $urandom_range(0, 1), e, f, cat == 2, $urandom_range(0, 1),
                  $urandom_range(0, 1), 2'($urandom_range(0, 3)), sg,
                  $urandom_range(0, 1), $urandom_range(0, 1));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule